// File: doc/BRIEF.md
# Receive Clock-Compensation Elastic Buffer

This block moves a stream of 64-bit Ethernet words, each with eight per-lane control bits, from the recovered receive clock into the local core clock. The two clocks may differ by up to ±200 ppm. The block absorbs that difference by keeping the store about half full. The write side drops idle words when the store holds more than half its depth. The read side emits one extra idle when it holds less than half.

After reset the read side first waits for the store to reach half depth, emitting fault words while it waits. If the store runs dry in steady state, the read side also emits the fault word rather than stale data and raises a sticky underflow flag. A data word that meets a full store is discarded, and a sticky overflow flag rises on the write side.

Read and write pointers cross between the domains in Gray code through two-stage synchronisers. Each side works out occupancy from its own pointer and the synchronised copy of the other side's pointer.

Top module: `rx_elastic_buf`

## Requirements
- R1: The store holds DEPTH (default 32) words of LANES×8 data bits plus LANES control bits. Words written with all control bits clear leave in the order written, with no loss and no duplication, as long as the store neither fills nor empties.
- R2: Each clock domain sees the other side's pointer only as a Gray-coded value, and that value changes by at most one bit per clock.
- R3: After reset, and until the read side sees at least DEPTH/2 words stored, the output is the fault word. The fault word has data 64'h0100009C_0100009C and control 8'h11: byte 0x9C with its control bit set in lanes 0 and 4, byte 0x01 in lanes 3 and 7, and zero bytes with clear control bits elsewhere.
- R4: An idle word has every control bit set and every byte equal to 0x07. An idle offered while the write side counts more than DEPTH/2 words stored is discarded and never appears at the output.
- R5: In steady state, one extra idle is emitted without advancing the read pointer when both of these hold: the read side counts fewer than DEPTH/2 words, and the last word taken from the store was an idle. At most one idle is added per stored word taken.
- R6: In steady state an empty store yields the fault word at the output and sets rd_underflow. The flag stays set until rd_rst.
- R7: A non-idle word offered while the write side counts DEPTH words stored is discarded and sets wr_overflow. The flag stays set until wr_rst. The stored words are not disturbed.
- R8: With the write clock 200 ppm fast or 200 ppm slow against the read clock, and an idle at least once every 32 words, every data word arrives in order and neither flag rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered receive clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_en | input | 1 | Word present on wr_data/wr_ctrl this cycle |
| wr_data | input | LANES*8 | Incoming data bytes, lane 0 in the low byte |
| wr_ctrl | input | LANES | Incoming per-lane control bits |
| wr_overflow | output | 1 | Sticky: a data word met a full store |
| rd_clk | input | 1 | Local core clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_data | output | LANES*8 | Outgoing data bytes |
| rd_ctrl | output | LANES | Outgoing per-lane control bits |
| rd_underflow | output | 1 | Sticky: the store ran empty in steady state |

## Verification
The bench builds the block with its defaults, eight lanes and 32 entries, so the half-depth threshold of 16 and the full level of 32 are reached within a few dozen writes. Holding the read domain in reset while the write side runs gives exact occupancies. That makes the idle drop above half, the single idle insertion below half, the overflow at 32 and the drain into underflow each land on a predictable word. The two 200 ppm streams, run for tens of thousands of words, drive the regulation loop in both directions against the synchroniser lag.

// File: rtl/ebuf_pkg.sv
package ebuf_pkg;

    localparam logic [7:0] IDLE_BYTE  = 8'h07;
    localparam logic [7:0] FAULT_HEAD = 8'h9C;
    localparam logic [7:0] FAULT_TAIL = 8'h01;
    localparam int         GMAX       = 16;

    typedef enum logic {
        RD_FILL,
        RD_RUN
    } rd_phase_e;

    typedef enum logic [1:0] {
        SRC_FAULT,
        SRC_MEM,
        SRC_IDLE
    } rd_src_e;

    function automatic logic [GMAX-1:0] to_gray(input logic [GMAX-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [GMAX-1:0] from_gray(input logic [GMAX-1:0] g);
        logic [GMAX-1:0] b;
        b[GMAX-1] = g[GMAX-1];
        for (int i = GMAX - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    // Fault pattern repeats every four lanes: head byte, two zeros, tail byte
    function automatic logic [7:0] fault_byte(input int lane);
        case (lane % 4)
            0:       return FAULT_HEAD;
            3:       return FAULT_TAIL;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic fault_ctl(input int lane);
        return (lane % 4) == 0;
    endfunction

endpackage

// File: rtl/ebuf_sync.sv
module ebuf_sync #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/ebuf_ram.sv
module ebuf_ram #(
    parameter int DEPTH = 32,
    parameter int AW    = 5,
    parameter int WW    = 72
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [WW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [WW-1:0] rdata
);
    logic [WW-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/ebuf_wr_side.sv
module ebuf_wr_side
    import ebuf_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int AW    = 5,
    parameter int PW    = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          push_idle,
    input  logic [PW-1:0] rd_gray_s,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [PW-1:0] wr_gray,
    output logic          overflow
);
    logic [PW-1:0] wbin;
    logic [PW-1:0] rbin;
    logic [PW-1:0] occ;
    logic [PW-1:0] wbin_nx;
    logic          full;
    logic          above_half;

    assign rbin       = PW'(from_gray(GMAX'(rd_gray_s)));
    assign occ        = wbin - rbin;
    assign full       = (occ == PW'(DEPTH));
    assign above_half = (occ > PW'(DEPTH / 2));
    assign wbin_nx    = wbin + PW'(1);

    // Idles are surplus when above half; anything is lost when full
    assign mem_we    = push && !full && !(push_idle && above_half);
    assign mem_waddr = wbin[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin     <= '0;
            wr_gray  <= '0;
            overflow <= 1'b0;
        end else begin
            if (mem_we) begin
                wbin    <= wbin_nx;
                wr_gray <= PW'(to_gray(GMAX'(wbin_nx)));
            end
            if (push && full && !push_idle) begin
                overflow <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ebuf_rd_side.sv
module ebuf_rd_side
    import ebuf_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int AW    = 5,
    parameter int PW    = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] wr_gray_s,
    input  logic          head_idle,
    output logic [AW-1:0] raddr,
    output rd_src_e       src,
    output logic [PW-1:0] rd_gray,
    output logic          underflow
);
    rd_phase_e     phase;
    logic [PW-1:0] rbin;
    logic [PW-1:0] wbin;
    logic [PW-1:0] occ;
    logic [PW-1:0] rbin_nx;
    logic          last_idle;
    logic          take;

    assign wbin    = PW'(from_gray(GMAX'(wr_gray_s)));
    assign occ     = wbin - rbin;
    assign rbin_nx = rbin + PW'(1);
    assign raddr   = rbin[AW-1:0];

    always_comb begin
        src  = SRC_FAULT;
        take = 1'b0;
        if (phase == RD_RUN) begin
            if (occ == '0) begin
                src = SRC_FAULT;
            end else if (occ < PW'(DEPTH / 2) && last_idle) begin
                src = SRC_IDLE;
            end else begin
                src  = SRC_MEM;
                take = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= RD_FILL;
            rbin      <= '0;
            rd_gray   <= '0;
            last_idle <= 1'b0;
            underflow <= 1'b0;
        end else begin
            if (phase == RD_FILL && occ >= PW'(DEPTH / 2)) begin
                phase <= RD_RUN;
            end
            if (take) begin
                rbin      <= rbin_nx;
                rd_gray   <= PW'(to_gray(GMAX'(rbin_nx)));
                last_idle <= head_idle;
            end else if (phase == RD_RUN) begin
                last_idle <= 1'b0;
            end
            if (phase == RD_RUN && occ == '0) begin
                underflow <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rx_elastic_buf.sv
module rx_elastic_buf
    import ebuf_pkg::*;
#(
    parameter int LANES = 8,
    parameter int DEPTH = 32
) (
    input  logic               wr_clk,
    input  logic               wr_rst,
    input  logic               wr_en,
    input  logic [LANES*8-1:0] wr_data,
    input  logic [LANES-1:0]   wr_ctrl,
    output logic               wr_overflow,
    input  logic               rd_clk,
    input  logic               rd_rst,
    output logic [LANES*8-1:0] rd_data,
    output logic [LANES-1:0]   rd_ctrl,
    output logic               rd_underflow
);
    localparam int DW = LANES * 8;
    localparam int CW = LANES;
    localparam int WW = DW + CW;
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [DW-1:0] idle_d;
    logic [DW-1:0] fault_d;
    logic [CW-1:0] fault_c;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign idle_d[l*8 +: 8]  = IDLE_BYTE;
        assign fault_d[l*8 +: 8] = fault_byte(l);
        assign fault_c[l]        = fault_ctl(l);
    end

    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [AW-1:0] mem_raddr;
    logic [WW-1:0] mem_rdata;
    logic [PW-1:0] wr_gray;
    logic [PW-1:0] rd_gray;
    logic [PW-1:0] wr_gray_s;
    logic [PW-1:0] rd_gray_s;
    logic          push_idle;
    logic          head_idle;
    rd_src_e       src;

    assign push_idle = (wr_ctrl == '1) && (wr_data == idle_d);
    assign head_idle = (mem_rdata[DW +: CW] == '1) && (mem_rdata[DW-1:0] == idle_d);

    ebuf_sync #(.W(PW)) u_sync_r2w (
        .clk(wr_clk), .rst(wr_rst), .d(rd_gray), .q(rd_gray_s)
    );

    ebuf_sync #(.W(PW)) u_sync_w2r (
        .clk(rd_clk), .rst(rd_rst), .d(wr_gray), .q(wr_gray_s)
    );

    ebuf_wr_side #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
        .clk(wr_clk), .rst(wr_rst), .push(wr_en), .push_idle(push_idle),
        .rd_gray_s(rd_gray_s), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .wr_gray(wr_gray), .overflow(wr_overflow)
    );

    ebuf_ram #(.DEPTH(DEPTH), .AW(AW), .WW(WW)) u_ram (
        .wclk(wr_clk), .we(mem_we), .waddr(mem_waddr), .wdata({wr_ctrl, wr_data}),
        .raddr(mem_raddr), .rdata(mem_rdata)
    );

    ebuf_rd_side #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_rd (
        .clk(rd_clk), .rst(rd_rst), .wr_gray_s(wr_gray_s), .head_idle(head_idle),
        .raddr(mem_raddr), .src(src), .rd_gray(rd_gray), .underflow(rd_underflow)
    );

    always_ff @(posedge rd_clk) begin
        if (rd_rst) begin
            rd_data <= fault_d;
            rd_ctrl <= fault_c;
        end else begin
            case (src)
                SRC_MEM: begin
                    rd_data <= mem_rdata[DW-1:0];
                    rd_ctrl <= mem_rdata[DW +: CW];
                end
                SRC_IDLE: begin
                    rd_data <= idle_d;
                    rd_ctrl <= '1;
                end
                default: begin
                    rd_data <= fault_d;
                    rd_ctrl <= fault_c;
                end
            endcase
        end
    end
endmodule

// File: rtl/ebuf_checker.sv
module ebuf_checker
    import ebuf_pkg::*;
#(
    parameter int LANES = 8,
    parameter int PW    = 6
) (
    input logic               wr_clk,
    input logic               wr_rst,
    input logic               wr_en,
    input logic               wr_overflow,
    input logic [PW-1:0]      wr_gray,
    input logic               rd_clk,
    input logic               rd_rst,
    input logic [LANES*8-1:0] rd_data,
    input logic [LANES-1:0]   rd_ctrl,
    input logic               rd_underflow,
    input logic [PW-1:0]      rd_gray
);
    logic [LANES*8-1:0] lf_d;
    logic [LANES-1:0]   lf_c;

    for (genvar l = 0; l < LANES; l++) begin : g_ref
        assign lf_d[l*8 +: 8] = (l % 4 == 0) ? 8'h9C : ((l % 4 == 3) ? 8'h01 : 8'h00);
        assign lf_c[l]        = (l % 4 == 0);
    end

    a_r2_wr_gray_step: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $onehot0(wr_gray ^ $past(wr_gray)));

    a_r2_rd_gray_step: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $onehot0(rd_gray ^ $past(rd_gray)));

    a_r6_fault_on_underflow: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $rose(rd_underflow) |-> (rd_data == lf_d && rd_ctrl == lf_c));

    a_r6_underflow_sticky: assert property (@(posedge rd_clk) disable iff (rd_rst)
        rd_underflow |=> rd_underflow);

    a_r7_overflow_sticky: assert property (@(posedge wr_clk) disable iff (wr_rst)
        wr_overflow |=> wr_overflow);

    a_r7_overflow_needs_write: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $rose(wr_overflow) |-> $past(wr_en));
endmodule

bind rx_elastic_buf ebuf_checker #(.LANES(LANES), .PW(PW)) u_chk (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_overflow(wr_overflow),
    .wr_gray(wr_gray), .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_data(rd_data),
    .rd_ctrl(rd_ctrl), .rd_underflow(rd_underflow), .rd_gray(rd_gray)
);

// File: tb/tb_rx_elastic_buf.sv
`timescale 1ps/1ps
module tb_rx_elastic_buf;
    localparam int LANES   = 8;
    localparam int DEPTH   = 32;
    localparam int RD_HALF = 5000;
    localparam int ROUNDS  = 200;
    localparam logic [63:0] LF_D   = 64'h0100009C_0100009C;
    localparam logic [7:0]  LF_C   = 8'h11;
    localparam logic [63:0] IDLE_D = 64'h0707070707070707;
    localparam logic [7:0]  IDLE_C = 8'hFF;
    // Stimulus table: {data words, idle words}; expected result is the data sequence in order
    localparam int PATTERN [8][2] = '{'{31, 1}, '{5, 2}, '{17, 1}, '{1, 3},
                                      '{24, 1}, '{9, 1}, '{30, 2}, '{12, 4}};

    logic wr_clk = 0, rd_clk = 0, wr_rst = 1, rd_rst = 1, wr_en = 0;
    logic [63:0] wr_data = '0;
    logic [7:0]  wr_ctrl = '0;
    logic [63:0] rd_data;
    logic [7:0]  rd_ctrl;
    logic wr_overflow, rd_underflow;
    int wr_half = 5000;

    int checks = 0, errors = 0;
    bit mon_en = 0;
    int exp_seq, mon_bad, n_data, n_idle, n_lf, gap, probe_seq, probe_gap, sent;

    rx_elastic_buf #(.LANES(LANES), .DEPTH(DEPTH)) dut (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
        .wr_ctrl(wr_ctrl), .wr_overflow(wr_overflow), .rd_clk(rd_clk),
        .rd_rst(rd_rst), .rd_data(rd_data), .rd_ctrl(rd_ctrl),
        .rd_underflow(rd_underflow)
    );

    always #(RD_HALF) rd_clk = ~rd_clk;
    always #(wr_half) wr_clk = ~wr_clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Output monitor: classifies every read-side word
    always @(negedge rd_clk) begin
        if (mon_en) begin
            if (rd_ctrl == 8'h00) begin
                if (rd_data != {exp_seq[31:0], ~exp_seq[31:0]}) begin
                    mon_bad++;
                    if (mon_bad < 5) $display("stream mismatch got %h want seq %0d", rd_data, exp_seq);
                    exp_seq = int'(rd_data[63:32]) + 1;
                end else begin
                    if (exp_seq == probe_seq) probe_gap = gap;
                    exp_seq++;
                end
                n_data++;
                gap = 0;
            end else if (rd_ctrl == IDLE_C && rd_data == IDLE_D) begin
                n_idle++;
                gap++;
            end else if (rd_ctrl == LF_C && rd_data == LF_D) begin
                n_lf++;
            end else begin
                mon_bad++;
            end
        end
    end

    task automatic mon_clear();
        exp_seq = 0; mon_bad = 0; n_data = 0; n_idle = 0; n_lf = 0;
        gap = 0; probe_seq = -1; probe_gap = -1; sent = 0;
    endtask

    task automatic send(input logic [63:0] d, input logic [7:0] c);
        @(negedge wr_clk);
        wr_en = 1; wr_data = d; wr_ctrl = c;
    endtask

    task automatic send_data(input int n);
        send({n[31:0], ~n[31:0]}, 8'h00);
    endtask

    task automatic send_idle();
        send(IDLE_D, IDLE_C);
    endtask

    task automatic stop_wr();
        @(negedge wr_clk);
        wr_en = 0;
    endtask

    task automatic rd_cycles(input int n);
        repeat (n) @(negedge rd_clk);
    endtask

    // Write domain running, read domain held in reset
    task automatic start_wr_only();
        mon_en = 0; wr_rst = 1; rd_rst = 1; wr_en = 0;
        rd_cycles(4);
        wr_rst = 0;
        mon_clear();
    endtask

    task automatic release_rd();
        rd_cycles(6);
        mon_en = 1;
        rd_rst = 0;
    endtask

    task automatic run_stream(input string req);
        int seq = 0;
        mon_en = 0; wr_rst = 1; rd_rst = 1; wr_en = 0;
        rd_cycles(4);
        mon_clear();
        mon_en = 1; wr_rst = 0; rd_rst = 0;
        for (int r = 0; r < ROUNDS; r++) begin
            for (int p = 0; p < 8; p++) begin
                for (int k = 0; k < PATTERN[p][0]; k++) begin
                    send_data(seq);
                    seq++;
                end
                for (int k = 0; k < PATTERN[p][1]; k++) send_idle();
            end
        end
        sent = seq;
        chk(wr_overflow == 1'b0, req, "no overflow during stream", 64'(wr_overflow), 64'd0);
        chk(rd_underflow == 1'b0, req, "no underflow during stream", 64'(rd_underflow), 64'd0);
        stop_wr();
        rd_cycles(100);
        chk(n_data == sent, req, "data words delivered", 64'(n_data), 64'(sent));
        chk(mon_bad == 0, "R1", "order/duplication errors in stream", 64'(mon_bad), 64'd0);
    endtask

    initial begin
        #(64'(RD_HALF) * 2 * 190000);
        errors++;
        $display("FAIL R8 watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        mon_clear();
        // Reset state and fill phase (R3)
        rd_cycles(4);
        wr_rst = 0; rd_rst = 0;
        rd_cycles(3);
        chk(rd_data == LF_D, "R3", "data after reset", rd_data, LF_D);
        chk(rd_ctrl == LF_C, "R3", "ctrl after reset", 64'(rd_ctrl), 64'(LF_C));
        chk(rd_underflow == 1'b0, "R6", "underflow clear after reset", 64'(rd_underflow), 64'd0);
        chk(wr_overflow == 1'b0, "R7", "overflow clear after reset", 64'(wr_overflow), 64'd0);

        // R4: idles above half are deleted; then drain into underflow (R6)
        start_wr_only();
        for (int i = 0; i < 20; i++) send_data(i);
        for (int i = 0; i < 5; i++) send_idle();
        for (int i = 20; i < 23; i++) send_data(i);
        stop_wr();
        release_rd();
        rd_cycles(60);
        chk(n_idle == 0, "R4", "idles seen after deletion", 64'(n_idle), 64'd0);
        chk(n_data == 23, "R1", "data words delivered", 64'(n_data), 64'd23);
        chk(mon_bad == 0, "R1", "order errors", 64'(mon_bad), 64'd0);
        chk(rd_underflow == 1'b1, "R6", "underflow after drain", 64'(rd_underflow), 64'd1);
        chk(rd_data == LF_D && rd_ctrl == LF_C, "R6", "fault word when empty", rd_data, LF_D);
        chk(wr_overflow == 1'b0, "R7", "no overflow at 23 words", 64'(wr_overflow), 64'd0);

        // R5: a stored idle read below half is followed by one inserted idle
        start_wr_only();
        for (int i = 0; i < 10; i++) send_data(i);
        send_idle();
        for (int i = 10; i < 20; i++) send_data(i);
        stop_wr();
        probe_seq = 10;
        release_rd();
        rd_cycles(60);
        chk(probe_gap == 2, "R5", "idles before word 10", 64'(probe_gap), 64'd2);
        chk(n_idle == 2, "R5", "total idles", 64'(n_idle), 64'd2);
        chk(n_data == 20, "R1", "data words delivered", 64'(n_data), 64'd20);
        chk(mon_bad == 0, "R1", "order errors", 64'(mon_bad), 64'd0);

        // R7: 40 data words into 32 entries
        start_wr_only();
        for (int i = 0; i < 40; i++) send_data(i);
        stop_wr();
        rd_cycles(2);
        chk(wr_overflow == 1'b1, "R7", "overflow flag", 64'(wr_overflow), 64'd1);
        release_rd();
        rd_cycles(80);
        chk(n_data == DEPTH, "R7", "words kept", 64'(n_data), 64'(DEPTH));
        chk(exp_seq == DEPTH, "R7", "last sequence + 1", 64'(exp_seq), 64'(DEPTH));
        chk(mon_bad == 0, "R7", "order errors after overflow", 64'(mon_bad), 64'd0);
        chk(wr_overflow == 1'b1, "R7", "overflow still set", 64'(wr_overflow), 64'd1);

        // R8: write clock 200 ppm fast, then 200 ppm slow
        wr_half = 4999;
        run_stream("R8");
        wr_half = 5001;
        run_stream("R8");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule